// File: doc/BRIEF.md
# Conditional-Select Operand Steering Unit

This unit executes a bitwise three-input select on wide vector registers. Each result bit is taken from one of two data inputs, and the matching bit of a selector input decides which one. The unit receives instruction fields that have already been decoded: a destination index, a first-source index, a register-or-memory index with a flag that marks a memory operand, an immediate byte, a swap bit and a length bit. It holds a private file of 16 vector registers of 256 bits each. It reads its operands from that file, or takes one operand from a supplied memory data bus. It then computes the result and writes the destination register back into the file.

The swap bit sets which input the register-or-memory operand feeds and which input the register named by the upper immediate nibble feeds. The length bit chooses a 128-bit or a 256-bit result. When the result is 128 bits, the upper half of the destination is cleared.

An operation is issued by holding `issue_valid` high for one clock. One cycle later the unit shows the result on its write-back port and raises `done` for that single cycle. At the next edge the result enters the register file. An operation issued in the cycle right after a producer reads the new value through a forwarding path, so back-to-back dependent operations need no stall. The unit has no status flags. Parsing of instruction bytes, address generation and memory access take place outside the unit.

Top module: `csel_unit`

## Requirements
- R1: For every bit position, the result bit equals the first-source bit where the selector bit is 1 and the second-source bit where the selector bit is 0.
- R2: The first source is always the register indexed by `vvvv_idx`.
- R3: With `w_bit`=0, the second source is the register-or-memory operand (`rm_idx`, or `mem_data` when `rm_is_mem`=1), and the selector is the register indexed by `imm8[7:4]`.
- R4: With `w_bit`=1, the second source is the register indexed by `imm8[7:4]`, and the selector is the register-or-memory operand.
- R5: When `rm_is_mem`=1, `mem_data` replaces the register `rm_idx` for whichever input that operand feeds, and the content of register `rm_idx` has no effect on the result.
- R6: With `l_bit`=0, result bits [255:128] are zero, whatever the sources hold, including the upper half of `mem_data`. Bits [127:0] follow R1.
- R7: With `l_bit`=1, all 256 result bits follow R1.
- R8: When `issue_valid` is sampled high at a rising edge, `done` and `wb_en` are high for exactly the following cycle, with `wb_idx` equal to the issued `dst_idx` and `wb_data` equal to the result. At the next edge the result is stored in that register.
- R9: An operation issued in the cycle when a previous result is on the write-back port sees that result for any source that names the same register.
- R10: Synchronous active-high `rst` clears every vector register to zero and holds `done` and `wb_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issues one operation when high at a rising edge |
| dst_idx | input | 4 | Destination register index |
| vvvv_idx | input | 4 | First-source register index |
| rm_idx | input | 4 | Register-or-memory operand register index |
| rm_is_mem | input | 1 | 1: register-or-memory operand comes from `mem_data` |
| imm8 | input | 8 | Immediate byte; bits [7:4] name a register, bits [3:0] unused |
| w_bit | input | 1 | Swaps the inputs fed by the register-or-memory and immediate operands |
| l_bit | input | 1 | 0: 128-bit result with upper half cleared; 1: 256-bit result |
| mem_data | input | 256 | Memory operand data |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register file write enable |
| wb_idx | output | 4 | Register file write index |
| wb_data | output | 256 | Register file write data |

## Verification
The case that is hardest to reach from the ports is a dependent operation that reads a register in the same cycle as that register's pending write. Only that case exercises the forwarding path, and reaching it needs two issues on consecutive edges that share a register index. The register file can only be filled through the unit's own operations, so the bench first loads registers. Each load is a select with the zero register as selector and a memory operand, which copies `mem_data` into the destination. The bench then chains operations with no idle cycle, so that each new operation reads the register the previous one is still writing back. It uses the chained result as the selector in one case and as the first source in another. Memory data with a non-zero upper half, sent with the length bit clear, checks that the upper half is cleared.

// File: rtl/csel_pkg.sv
package csel_pkg;

    parameter int VLEN  = 256;
    parameter int NREG  = 16;
    parameter int NRD   = 3;

    localparam int IDX_W = $clog2(NREG);
    localparam int HALF  = VLEN / 2;

    // read-port numbering inside the register file
    localparam int RP_SRC1 = 0;
    localparam int RP_IMM  = 1;
    localparam int RP_RM   = 2;

    typedef logic [VLEN-1:0]  vec_t;
    typedef logic [IDX_W-1:0] ridx_t;

    // decoded operation as seen by the unit
    typedef struct packed {
        ridx_t dst;
        ridx_t src1;
        ridx_t imm_reg;
        ridx_t rm;
        logic  rm_mem;
        logic  swap;
        logic  wide;
    } uop_t;

    // steered operand bundle feeding the select datapath
    typedef struct packed {
        vec_t on_one;
        vec_t on_zero;
        vec_t sel;
        logic wide;
    } opnd_t;

    function automatic vec_t bit_pick(input vec_t s, input vec_t a, input vec_t b);
        return (s & a) | (~s & b);
    endfunction

    function automatic vec_t width_mask(input logic wide);
        vec_t m;
        for (int i = 0; i < VLEN; i++) begin
            m[i] = wide || (i < HALF);
        end
        return m;
    endfunction

endpackage

// File: rtl/csel_vrf.sv
module csel_vrf
    import csel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t widx,
    input  vec_t  wdata,
    input  ridx_t ridx [NRD],
    output vec_t  rdata [NRD]
);

    vec_t regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // read ports forward the pending write so a dependent op needs no stall
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (we && (widx == ridx[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = regs[ridx[p]];
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(widx)] == $past(wdata)));             // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (regs[0] == '0 && regs[NREG-1] == '0));          // R10

endmodule

// File: rtl/csel_steer.sv
module csel_steer
    import csel_pkg::*;
(
    input  uop_t  uop,
    input  vec_t  rd_src1,
    input  vec_t  rd_imm,
    input  vec_t  rd_rm,
    input  vec_t  mem_data,
    output opnd_t ops
);

    vec_t rm_val;

    always_comb begin
        rm_val = uop.rm_mem ? mem_data : rd_rm;

        ops.on_one = rd_src1;
        ops.wide   = uop.wide;
        if (uop.swap) begin
            ops.on_zero = rd_imm;
            ops.sel     = rm_val;
        end else begin
            ops.on_zero = rm_val;
            ops.sel     = rd_imm;
        end
    end

endmodule

// File: rtl/csel_blend.sv
module csel_blend
    import csel_pkg::*;
(
    input  opnd_t ops,
    output vec_t  res
);

    always_comb begin
        res = bit_pick(ops.sel, ops.on_one, ops.on_zero) & width_mask(ops.wide);
    end

endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] vvvv_idx,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic             rm_is_mem,
    input  logic [7:0]       imm8,
    input  logic             w_bit,
    input  logic             l_bit,
    input  logic [VLEN-1:0]  mem_data,
    output logic             done,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [VLEN-1:0]  wb_data
);

    uop_t  uop;
    opnd_t ops;
    vec_t  res;
    ridx_t rd_idx [NRD];
    vec_t  rd_val [NRD];
    logic  imm_lo_unused;

    assign imm_lo_unused = ^imm8[7-IDX_W:0];

    always_comb begin
        uop.dst     = dst_idx;
        uop.src1    = vvvv_idx;
        uop.imm_reg = imm8[7 -: IDX_W];
        uop.rm      = rm_idx;
        uop.rm_mem  = rm_is_mem;
        uop.swap    = w_bit;
        uop.wide    = l_bit;

        rd_idx[RP_SRC1] = uop.src1;
        rd_idx[RP_IMM]  = uop.imm_reg;
        rd_idx[RP_RM]   = uop.rm;
    end

    csel_vrf u_vrf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_en),
        .widx  (wb_idx),
        .wdata (wb_data),
        .ridx  (rd_idx),
        .rdata (rd_val)
    );

    csel_steer u_steer (
        .uop      (uop),
        .rd_src1  (rd_val[RP_SRC1]),
        .rd_imm   (rd_val[RP_IMM]),
        .rd_rm    (rd_val[RP_RM]),
        .mem_data (mem_data),
        .ops      (ops)
    );

    csel_blend u_blend (
        .ops (ops),
        .res (res)
    );

    // single write-back stage
    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            done <= issue_valid;
            if (issue_valid) begin
                wb_idx  <= uop.dst;
                wb_data <= res;
            end
        end
    end

    assign wb_en = done;

    AST_DONE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(issue_valid));                             // R8

    AST_ISSUE_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> done);                                    // R8

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !l_bit) |=> (wb_data[VLEN-1:HALF] == '0)); // R6

endmodule

// File: tb/tb_csel_unit.sv
module tb_csel_unit;
    import csel_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [3:0]  dst_idx, vvvv_idx, rm_idx;
    logic        rm_is_mem;
    logic [7:0]  imm8;
    logic        w_bit, l_bit;
    vec_t        mem_data;
    logic        done, wb_en;
    logic [3:0]  wb_idx;
    vec_t        wb_data;

    int tests = 0;
    int fails = 0;
    vec_t model [NREG];

    always #10 clk = ~clk;

    csel_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid),
        .dst_idx(dst_idx), .vvvv_idx(vvvv_idx), .rm_idx(rm_idx),
        .rm_is_mem(rm_is_mem), .imm8(imm8), .w_bit(w_bit), .l_bit(l_bit),
        .mem_data(mem_data), .done(done), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string req, input vec_t act, input vec_t exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue at a negedge; result checked at the next negedge; returns at a negedge
    task automatic op(input string req, input logic [3:0] d, input logic [3:0] v,
                      input logic [3:0] rm, input logic mem, input logic [3:0] ih,
                      input logic w, input logic l, input vec_t md);
        vec_t s1, s2, sl, rmv, e;
        rmv = mem ? md : model[rm];
        s1  = model[v];
        if (w) begin s2 = model[ih]; sl = rmv; end
        else   begin s2 = rmv;       sl = model[ih]; end
        for (int i = 0; i < VLEN; i++) e[i] = sl[i] ? s1[i] : s2[i];
        if (!l) e[VLEN-1:HALF] = '0;
        dst_idx = d; vvvv_idx = v; rm_idx = rm; rm_is_mem = mem;
        imm8 = {ih, 4'hA}; w_bit = w; l_bit = l; mem_data = md;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk({req, " done"}, vec_t'(done), vec_t'(1));
        chk({req, " wb_en"}, vec_t'(wb_en), vec_t'(1));
        chk({req, " wb_idx"}, vec_t'(wb_idx), vec_t'(d));
        chk({req, " data"}, wb_data, e);
        model[d] = e;
    endtask

    task automatic load(input logic [3:0] d, input vec_t val);
        op("R5 load", d, 4'd0, 4'd9, 1'b1, 4'd0, 1'b0, 1'b1, val);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk({req, " done low"}, vec_t'(done), vec_t'(0));
    endtask

    localparam vec_t PA = {8{32'hA5C3_0F96}};
    localparam vec_t PB = {8{32'h3C5A_E187}};
    localparam vec_t PS = {16{16'hFF00}} ^ {4{64'h0123_4567_89AB_CDEF}};

    task automatic t_reset;
        chk("R10 done", vec_t'(done), vec_t'(0));
        chk("R10 wb_en", vec_t'(wb_en), vec_t'(0));
        op("R10 zero regs", 4'd7, 4'd3, 4'd4, 1'b0, 4'd5, 1'b0, 1'b1, '1);
        idle_check("R8");
    endtask

    task automatic t_loads;
        load(4'd1, PA);
        load(4'd2, PB);
        load(4'd3, PS);
        load(4'd8, '1);
        idle_check("R8");
    endtask

    task automatic t_w0;
        op("R1 R2 R3 R7 w0 reg", 4'd4, 4'd1, 4'd2, 1'b0, 4'd3, 1'b0, 1'b1, '0);
        op("R1 all-ones sel", 4'd5, 4'd2, 4'd1, 1'b0, 4'd8, 1'b0, 1'b1, '0);
        op("R3 w0 mem", 4'd6, 4'd1, 4'd2, 1'b1, 4'd3, 1'b0, 1'b1, PS ^ PB);
        idle_check("R8");
    endtask

    task automatic t_w1;
        op("R4 w1 reg", 4'd9, 4'd1, 4'd3, 1'b0, 4'd2, 1'b1, 1'b1, '0);
        op("R4 R5 w1 mem", 4'd10, 4'd2, 4'd3, 1'b1, 4'd1, 1'b1, 1'b1, ~PS);
        op("R5 rm ignored", 4'd11, 4'd1, 4'd8, 1'b1, 4'd2, 1'b1, 1'b1, '0);
    endtask

    task automatic t_narrow;
        op("R6 narrow mem", 4'd12, 4'd1, 4'd2, 1'b1, 4'd3, 1'b0, 1'b0, '1);
        op("R6 narrow reg", 4'd13, 4'd8, 4'd2, 1'b0, 4'd3, 1'b1, 1'b0, '0);
        op("R6 readback", 4'd14, 4'd0, 4'd12, 1'b0, 4'd0, 1'b0, 1'b1, '0);
    endtask

    task automatic t_chain;
        load(4'd6, PS ^ PA);
        op("R9 fwd sel", 4'd7, 4'd1, 4'd2, 1'b0, 4'd6, 1'b0, 1'b1, '0);
        op("R9 fwd src1", 4'd15, 4'd7, 4'd0, 1'b0, 4'd3, 1'b0, 1'b1, '0);
        op("R9 fwd self", 4'd15, 4'd15, 4'd15, 1'b0, 4'd3, 1'b1, 1'b1, '0);
        idle_check("R8");
        op("R8 stored", 4'd5, 4'd0, 4'd15, 1'b0, 4'd0, 1'b0, 1'b1, '0);
        idle_check("R8");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        rst = 1'b1; issue_valid = 1'b0; dst_idx = '0; vvvv_idx = '0; rm_idx = '0;
        rm_is_mem = 1'b0; imm8 = '0; w_bit = 1'b0; l_bit = 1'b0; mem_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_loads;
        t_w0;
        t_w1;
        t_narrow;
        t_chain;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule